// File: doc/BRIEF.md
# Dual-Width Integer Execute Stage

This block is the arithmetic execute stage of a 64-bit virtual processor. Each cycle it may accept one instruction of the arithmetic class. The instruction carries a width class, a 4-bit operation code and a bit that selects the second operand. The second operand is either the source register value or a 32-bit immediate. The block computes the new destination value and registers it. One cycle after acceptance it presents that value together with a valid strobe.

A single datapath serves both widths. The 64-bit class works on full register values. In that class a 32-bit immediate is sign-extended to 64 bits. The 32-bit class uses only the low halves of both operands, treats them as unsigned, and zero-extends the 32-bit result into the 64-bit destination. Encodings that are not in the set below are dropped: no strobe is raised and the last result stays on the output.

Top module: `vm_alu_exec`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `result` is 0 until the first legal instruction is accepted.
- R2: A legal instruction presented with `in_valid` high raises `out_valid` on the next clock edge, with its result on `result`. A cycle with no legal instruction gives `out_valid` low on the next edge and leaves `result` unchanged.
- R3: Width class 3'b100 selects 32-bit operation and 3'b111 selects 64-bit operation. Any other class value is dropped: no strobe, and `result` is held.
- R4: `use_reg`=1 selects `src` as the second operand and `use_reg`=0 selects `imm`. In the 64-bit class the immediate is sign-extended from bit 31.
- R5: In the 32-bit class both operands are the low 32 bits taken as unsigned, and the 32-bit result is written with bits 63:32 cleared.
- R6: The operation codes are ADD=0, SUB=1, MUL=2, DIV=3, OR=4, AND=5, LSH=6, RSH=7, NEG=8, MOD=9, XOR=A and MOV=B, plus ARSH=C (R7). Add, subtract and multiply wrap modulo the operating width.
- R7: LSH shifts left and RSH shifts right logically. ARSH shifts right and replicates the sign bit of the operating width. The shift count is the second operand masked to 6 bits in the 64-bit class and to 5 bits in the 32-bit class.
- R8: DIV is an unsigned divide. A zero divisor gives a result of 0.
- R9: MOD is an unsigned remainder. A zero divisor gives the destination operand unchanged, which in the 32-bit class is its low half zero-extended.
- R10: NEG gives the two's-complement negation of the destination operand at the operating width. The second operand has no effect.
- R11: MOV gives the selected second operand, following the width rules of R4 and R5.
- R12: Operation codes D, E and F are dropped: no strobe, and `result` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| cls | input | 3 | Width class (3'b100 = 32-bit, 3'b111 = 64-bit) |
| op | input | 4 | Operation code |
| use_reg | input | 1 | Second operand select: 1 = source register, 0 = immediate |
| dst | input | 64 | Destination register value (first operand) |
| src | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| out_valid | output | 1 | Result strobe, one cycle after a legal instruction |
| result | output | 64 | New destination value |

## Verification
The bench targets the places where the two widths diverge. One case is an all-ones immediate: it must act as -1 in the 64-bit class and as 0xFFFFFFFF in the 32-bit class. A wrong extension gives results that are off by 2^32. Another case is a destination with its upper half set in the 32-bit class: a block that fails to clear that half returns stale upper bits.

Shift counts above the width check the masking, since an unmasked shift returns zero. Arithmetic right shift in the 32-bit class must take its sign from bit 31, not bit 63.

Zero divisors check both fallback rules. A swapped rule would return the destination for a divide or 0 for a remainder.

NEG is driven with a non-zero source to show that the source has no effect. Illegal classes and operation codes are sent between legal instructions. A design that decodes them would raise a stray strobe or overwrite the held result.

// File: rtl/vm_alu_exec.sv
module vm_alu_exec #(
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       cls,
  input  logic [3:0]       op,
  input  logic             use_reg,
  input  logic [W-1:0]     dst,
  input  logic [W-1:0]     src,
  input  logic [W/2-1:0]   imm,
  output logic             out_valid,
  output logic [W-1:0]     result
);
  localparam int H  = W / 2;
  localparam int SW = $clog2(W);

  wire is32  = (cls == 3'b100);
  wire is64  = (cls == 3'b111);
  wire op_ok = (op <= 4'hC);
  wire fire  = in_valid && (is32 || is64) && op_ok;

  wire [W-1:0] b64 = use_reg ? src : {{(W-H){imm[H-1]}}, imm};
  wire [H-1:0] a32 = dst[H-1:0];
  wire [H-1:0] b32 = use_reg ? src[H-1:0] : imm;
  wire [SW-1:0] sh64 = b64[SW-1:0];
  wire [SW-2:0] sh32 = b32[SW-2:0];

  logic [W-1:0] r64;
  logic [H-1:0] r32;

  always_comb begin
    case (op)
      4'h0: r64 = dst + b64;
      4'h1: r64 = dst - b64;
      4'h2: r64 = dst * b64;
      4'h3: r64 = (b64 == '0) ? '0 : dst / b64;
      4'h4: r64 = dst | b64;
      4'h5: r64 = dst & b64;
      4'h6: r64 = dst << sh64;
      4'h7: r64 = dst >> sh64;
      4'h8: r64 = '0 - dst;
      4'h9: r64 = (b64 == '0) ? dst : dst % b64;
      4'hA: r64 = dst ^ b64;
      4'hB: r64 = b64;
      4'hC: r64 = $unsigned($signed(dst) >>> sh64);
      default: r64 = '0;
    endcase
  end

  always_comb begin
    case (op)
      4'h0: r32 = a32 + b32;
      4'h1: r32 = a32 - b32;
      4'h2: r32 = a32 * b32;
      4'h3: r32 = (b32 == '0) ? '0 : a32 / b32;
      4'h4: r32 = a32 | b32;
      4'h5: r32 = a32 & b32;
      4'h6: r32 = a32 << sh32;
      4'h7: r32 = a32 >> sh32;
      4'h8: r32 = '0 - a32;
      4'h9: r32 = (b32 == '0) ? a32 : a32 % b32;
      4'hA: r32 = a32 ^ b32;
      4'hB: r32 = b32;
      4'hC: r32 = $unsigned($signed(a32) >>> sh32);
      default: r32 = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= fire;
      if (fire) result <= is32 ? {{(W-H){1'b0}}, r32} : r64;
    end
  end
endmodule

// File: rtl/vm_alu_exec_chk.sv
module vm_alu_exec_chk #(
  parameter int W = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [2:0]     cls,
  input logic [3:0]     op,
  input logic           use_reg,
  input logic [W-1:0]   dst,
  input logic [W-1:0]   src,
  input logic [W/2-1:0] imm,
  input logic           out_valid,
  input logic [W-1:0]   result
);
  localparam int H = W / 2;

  wire legal  = in_valid && (cls == 3'b100 || cls == 3'b111) && (op <= 4'hC);
  wire w64    = in_valid && cls == 3'b111;
  wire [W-1:0] imm_x = {{(W-H){imm[H-1]}}, imm};

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    legal |=> out_valid); // R2

  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> (!out_valid && $stable(result))); // R3

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && cls == 3'b100) |=> (result[W-1:H] == '0)); // R5

  AST_MOV_IMM_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (w64 && op == 4'hB && !use_reg) |=> (result == $past(imm_x))); // R11

  AST_NEG_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (w64 && op == 4'h8) |=> (result == W'(0) - $past(dst))); // R10

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (w64 && op == 4'h3 && use_reg && src == '0) |=> (result == '0)); // R8
endmodule

bind vm_alu_exec vm_alu_exec_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cls(cls), .op(op),
  .use_reg(use_reg), .dst(dst), .src(src), .imm(imm),
  .out_valid(out_valid), .result(result)
);

// File: tb/sim_vm_alu_exec.sv
module sim_vm_alu_exec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] cls = 3'b0;
  logic [3:0] op = 4'h0;
  logic use_reg = 1'b0;
  logic [63:0] dst = '0, src = '0;
  logic [31:0] imm = '0;
  logic out_valid;
  logic [63:0] result;

  always #10 clk = ~clk;

  vm_alu_exec u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cls(cls), .op(op),
    .use_reg(use_reg), .dst(dst), .src(src), .imm(imm),
    .out_valid(out_valid), .result(result)
  );

  typedef struct {
    int          stamp;
    logic        v;
    logic [63:0] val;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  logic [63:0] held = '0;

  always @(posedge clk) cyc <= cyc + 1;

  localparam logic [2:0] C32 = 3'b100, C64 = 3'b111;

  function automatic logic [63:0] ref64(logic [3:0] o, logic [63:0] a, logic [63:0] b);
    case (o)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h2: return a * b;
      4'h3: return (b == 0) ? 64'd0 : a / b;
      4'h4: return a | b;
      4'h5: return a & b;
      4'h6: return a << b[5:0];
      4'h7: return a >> b[5:0];
      4'h8: return -a;
      4'h9: return (b == 0) ? a : a % b;
      4'hA: return a ^ b;
      4'hB: return b;
      default: return $unsigned($signed(a) >>> b[5:0]);
    endcase
  endfunction

  function automatic logic [31:0] ref32(logic [3:0] o, logic [31:0] a, logic [31:0] b);
    case (o)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h2: return a * b;
      4'h3: return (b == 0) ? 32'd0 : a / b;
      4'h4: return a | b;
      4'h5: return a & b;
      4'h6: return a << b[4:0];
      4'h7: return a >> b[4:0];
      4'h8: return -a;
      4'h9: return (b == 0) ? a : a % b;
      4'hA: return a ^ b;
      4'hB: return b;
      default: return $unsigned($signed(a) >>> b[4:0]);
    endcase
  endfunction

  task automatic drive(bit v, logic [2:0] c, logic [3:0] o, bit r,
                       logic [63:0] d, logic [63:0] s, logic [31:0] i, string tag);
    item_t it;
    bit ok;
    logic [63:0] b;
    @(negedge clk);
    in_valid = v; cls = c; op = o; use_reg = r; dst = d; src = s; imm = i;
    ok = v && (c == C32 || c == C64) && (o <= 4'hC);
    if (ok) begin
      if (c == C64) begin
        b = r ? s : {{32{i[31]}}, i};
        held = ref64(o, d, b);
      end else begin
        held = {32'd0, ref32(o, d[31:0], r ? s[31:0] : i)};
      end
    end
    it.stamp = cyc; it.v = ok; it.val = held; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].stamp < cyc) begin
      item_t it;
      it = q.pop_front();
      nchk++;
      if (out_valid !== it.v || result !== it.val) begin
        nfail++;
        $display("FAIL %s: got valid=%0b result=%h, expected valid=%0b result=%h",
                 it.tag, out_valid, result, it.v, it.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0 || result !== 64'd0) begin
      nfail++;
      $display("FAIL R1: got valid=%0b result=%h, expected valid=0 result=0", out_valid, result);
    end
    rst_n = 1'b1;
    drive(0, C64, 4'h0, 1, 64'd1, 64'd2, 32'd0, "R1 idle after reset");
    drive(1, C64, 4'h0, 1, 64'd5, 64'd7, 32'd99, "R6 add64 reg");
    drive(1, C64, 4'h1, 0, 64'd10, 64'd50, 32'd3, "R6 sub64 imm");
    drive(1, C64, 4'h1, 1, 64'd0, 64'd1, 32'd0, "R6 sub64 wrap");
    drive(0, C64, 4'h0, 1, 64'd9, 64'd9, 32'd0, "R2 idle holds");
    drive(1, C64, 4'h0, 0, 64'd5, 64'd0, 32'hFFFF_FFFF, "R4 imm sign-extended");
    drive(1, C32, 4'h0, 0, 64'hAAAA_0000_0000_0001, 64'd0, 32'hFFFF_FFFF, "R4 R5 add32 imm zero-extended");
    drive(1, C32, 4'h0, 1, 64'h1234_5678_FFFF_FFFF, 64'hFFFF_0000_0000_0001, 32'd0, "R5 add32 upper clear");
    drive(1, C64, 4'h2, 1, 64'h1_0000_0001, 64'h1_0000_0003, 32'd0, "R6 mul64 wrap");
    drive(1, C32, 4'h2, 1, 64'h0000_0000_8000_0001, 64'd4, 32'd0, "R6 mul32 wrap");
    drive(1, C64, 4'h4, 1, 64'hF0F0, 64'h0F0F_0000, 32'd0, "R6 or64");
    drive(1, C64, 4'h5, 0, 64'hFFFF_0000_FFFF_FFFF, 64'd0, 32'h8000_00FF, "R6 and64 imm");
    drive(1, C32, 4'hA, 1, 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0000_FFFF_FFFF, 32'd0, "R6 xor32");
    drive(1, C64, 4'h6, 0, 64'd3, 64'd0, 32'd65, "R7 lsh64 count masked");
    drive(1, C32, 4'h6, 0, 64'd3, 64'd0, 32'd33, "R7 lsh32 count masked");
    drive(1, C64, 4'h7, 1, 64'h8000_0000_0000_0000, 64'd4, 32'd0, "R7 rsh64 logical");
    drive(1, C64, 4'hC, 1, 64'h8000_0000_0000_0000, 64'd4, 32'd0, "R7 arsh64 sign fill");
    drive(1, C32, 4'hC, 1, 64'h0000_0000_8000_0000, 64'd4, 32'd0, "R7 arsh32 sign from bit 31");
    drive(1, C32, 4'h7, 1, 64'hFFFF_FFFF_8000_0000, 64'd36, 32'd0, "R7 rsh32 masked");
    drive(1, C64, 4'h3, 0, 64'd100, 64'd0, 32'd7, "R8 div64");
    drive(1, C64, 4'h3, 1, 64'd100, 64'd0, 32'd7, "R8 div64 by zero");
    drive(1, C32, 4'h3, 1, 64'h1_0000_0064, 64'h1_0000_0000, 32'd0, "R8 div32 by zero low half");
    drive(1, C64, 4'h9, 1, 64'd100, 64'd7, 32'd0, "R9 mod64");
    drive(1, C64, 4'h9, 0, 64'h1234_5678_9ABC_DEF0, 64'd3, 32'd0, "R9 mod64 by zero");
    drive(1, C32, 4'h9, 1, 64'hFFFF_0000_0000_0064, 64'hF_0000_0000, 32'd5, "R9 mod32 by zero");
    drive(1, C64, 4'h8, 1, 64'd5, 64'hDEAD_BEEF, 32'h1234, "R10 neg64 source ignored");
    drive(1, C32, 4'h8, 0, 64'hFFFF_FFFF_0000_0001, 64'd77, 32'h55, "R10 neg32");
    drive(1, C64, 4'hB, 0, 64'd1, 64'd2, 32'h8000_0000, "R11 mov64 imm");
    drive(1, C32, 4'hB, 1, 64'd1, 64'hABCD_EF01_2345_6789, 32'd0, "R11 mov32 reg");
    drive(1, C64, 4'hB, 1, 64'd1, 64'hABCD_EF01_2345_6789, 32'd0, "R11 mov64 reg");
    drive(1, 3'b101, 4'h0, 1, 64'd1, 64'd1, 32'd0, "R3 class 101 dropped");
    drive(1, 3'b000, 4'hB, 0, 64'd1, 64'd1, 32'd7, "R3 class 000 dropped");
    drive(1, C64, 4'hE, 1, 64'd1, 64'd1, 32'd0, "R12 op E dropped");
    drive(1, C32, 4'hD, 1, 64'd1, 64'd1, 32'd0, "R12 op D dropped");
    drive(1, C64, 4'h0, 0, 64'd40, 64'd0, 32'd2, "R2 back-to-back a");
    drive(1, C64, 4'h1, 0, 64'd40, 64'd0, 32'd2, "R2 back-to-back b");
    drive(0, C64, 4'h0, 0, 64'd0, 64'd0, 32'd0, "R2 drain");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule